// File: doc/BRIEF.md
# Single-Position Shift and Rotate Unit with Carry

This block is the one-step shift stage of a small processor datapath. In one pass it takes a register operand, a size code that picks the active field (byte, word or long), an operation code and the current carry flag. It returns the operand shifted, rotated or inverted by exactly one position, together with new negative, zero, overflow and carry flags.

The block is purely combinational. The result always spans the full register width. Bits above the active field are copied unchanged from the operand, so the datapath can write the whole value back to the source register without a merge step of its own.

The carry flag holds the bit that leaves the field. For the rotate-through-carry operations, the incoming carry is the bit that enters the field. Multi-position shifting, operand selection and instruction decoding belong to other blocks.

Top module: `shift_rot_unit`

## Requirements
- R1: Size code 0 selects bits 7:0, code 1 selects bits 15:0, and codes 2 and 3 select bits 31:0. Result bits above the active field equal the operand bits.
- R2: Operation codes 0 (logical left) and 2 (arithmetic left) give field<<1 with a zero in bit 0, and set C to the old field MSB.
- R3: Operation code 1 (logical right) gives field>>1 with a zero in the field MSB, and sets C to the old bit 0.
- R4: Operation code 3 (arithmetic right) gives field>>1 with the field MSB kept at its old value, and sets C to the old bit 0.
- R5: Operation code 4 (rotate left) moves the old MSB into both bit 0 and C. Operation code 5 (rotate right) moves the old bit 0 into both the MSB and C.
- R6: Operation code 6 (rotate left through carry) shifts left, places the incoming carry in bit 0, and sets C to the old MSB.
- R7: Operation code 7 (rotate right through carry) shifts right, places the incoming carry in the field MSB, and sets C to the old bit 0.
- R8: Operation code 8 inverts every field bit and leaves C equal to the incoming carry.
- R9: N equals the MSB of the result field. Z is 1 exactly when every bit of the result field is 0.
- R10: V is 0 for every operation and size.
- R11: Operation codes 9 to 15 return the operand unchanged and leave C equal to the incoming carry. N and Z are still computed as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Register operand |
| size_i | input | 2 | Active field size code |
| op_i | input | 4 | Operation code |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Full-width result for writeback |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | New carry flag |

## Verification
Because the block has no state, a wrong internal choice shows at the ports in the same evaluation as the stimulus. Typical faults are:
- a lane picked for the wrong size;
- a fill bit taken from the wrong source;
- a carry taken from the wrong end of the field;
- a mask that lets upper bits leak.

Each of these shows as a wrong result bit, a wrong carry, or an N or Z flag read from the wrong bit position. The byte field is therefore swept over every operand value, carry value and operation code. The word and long fields are driven with edge patterns and pseudo-random values. Every output is compared against an arithmetic model that uses masks, multiplication and division rather than bit slicing.

// File: rtl/srot_pkg.sv
package srot_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SHL_LOG = 4'd0,
    OP_SHR_LOG = 4'd1,
    OP_SHL_ARI = 4'd2,
    OP_SHR_ARI = 4'd3,
    OP_ROT_L   = 4'd4,
    OP_ROT_R   = 4'd5,
    OP_RCY_L   = 4'd6,
    OP_RCY_R   = 4'd7,
    OP_INVERT  = 4'd8
  } srot_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_ALT  = 2'd3
  } srot_size_e;

endpackage

// File: rtl/srot_lane.sv
module srot_lane
  import srot_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic [LW-1:0]   opnd_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            cin_i,
  output logic [LW-1:0]   res_o,
  output logic            cout_o
);

  // Returns {carry_out, field} for a one-position operation.
  function automatic logic [LW:0] step(input logic [LW-1:0] v,
                                       input logic [OP_W-1:0] op,
                                       input logic ci);
    logic msb, lsb;
    msb = v[LW-1];
    lsb = v[0];
    case (op)
      OP_SHL_LOG, OP_SHL_ARI: step = {msb, v[LW-2:0], 1'b0};
      OP_SHR_LOG:             step = {lsb, 1'b0, v[LW-1:1]};
      OP_SHR_ARI:             step = {lsb, msb, v[LW-1:1]};
      OP_ROT_L:               step = {msb, v[LW-2:0], msb};
      OP_ROT_R:               step = {lsb, lsb, v[LW-1:1]};
      OP_RCY_L:               step = {msb, v[LW-2:0], ci};
      OP_RCY_R:               step = {lsb, ci, v[LW-1:1]};
      OP_INVERT:              step = {ci, ~v};
      default:                step = {ci, v};
    endcase
  endfunction

  logic [LW:0] stepped;
  logic        is_rot, is_rcy;

  assign stepped = step(opnd_i, op_i, cin_i);
  assign res_o   = stepped[LW-1:0];
  assign cout_o  = stepped[LW];
  assign is_rot  = (op_i == OP_ROT_L) || (op_i == OP_ROT_R);
  assign is_rcy  = (op_i == OP_RCY_L) || (op_i == OP_RCY_R);

  always_comb begin
    if (is_rot)
      AST_ROT_KEEPS_ONES: assert ($countones(res_o) == $countones(opnd_i)); // R5
    if (is_rcy)
      AST_RCY_KEEPS_ONES: assert (($countones(res_o) + 32'(cout_o)) ==
                                  ($countones(opnd_i) + 32'(cin_i))); // R6
    if (op_i == OP_SHR_ARI)
      AST_SIGN_HELD: assert (res_o[LW-1] == opnd_i[LW-1]); // R4
  end

endmodule

// File: rtl/srot_flags.sv
module srot_flags #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] field_mask_i,
  output logic              neg_o,
  output logic              zero_o
);

  logic [DATA_W-1:0] top_bit;
  logic [DATA_W-1:0] field_bits;

  // The single highest bit of the mask marks the field MSB.
  assign top_bit    = field_mask_i ^ (field_mask_i >> 1);
  assign field_bits = res_i & field_mask_i;
  assign neg_o      = |(res_i & top_bit);
  assign zero_o     = (field_bits == '0);

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import srot_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [1:0]        size_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o
);

  localparam int NL = 3;

  function automatic logic [DATA_W-1:0] mask_for(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: mask_for = DATA_W'({(DATA_W/4){1'b1}});
      SZ_WORD: mask_for = DATA_W'({(DATA_W/2){1'b1}});
      default: mask_for = {DATA_W{1'b1}};
    endcase
  endfunction

  logic [DATA_W-1:0] lane_res [NL];
  logic              lane_c   [NL];
  logic [1:0]        lane_sel;
  logic [DATA_W-1:0] field_mask;
  logic [DATA_W-1:0] picked;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    localparam int LW = DATA_W >> (NL - 1 - k);
    logic [LW-1:0] r;
    logic          c;
    srot_lane #(.LW(LW)) u_lane (
      .opnd_i (opnd_i[LW-1:0]),
      .op_i   (op_i),
      .cin_i  (carry_i),
      .res_o  (r),
      .cout_o (c)
    );
    assign lane_res[k] = DATA_W'(r);
    assign lane_c[k]   = c;
  end

  assign lane_sel   = (size_i == SZ_BYTE) ? 2'd0 : (size_i == SZ_WORD) ? 2'd1 : 2'd2;
  assign field_mask = mask_for(size_i);
  assign picked     = lane_res[lane_sel];
  assign result_o   = (picked & field_mask) | (opnd_i & ~field_mask);
  assign flag_c_o   = lane_c[lane_sel];
  assign flag_v_o   = 1'b0;

  srot_flags #(.DATA_W(DATA_W)) u_flags (
    .res_i        (result_o),
    .field_mask_i (field_mask),
    .neg_o        (flag_n_o),
    .zero_o       (flag_z_o)
  );

  always_comb begin
    AST_UPPER_KEPT: assert (((result_o ^ opnd_i) & ~field_mask) == '0); // R1
    AST_N_Z_EXCLUSIVE: assert (!(flag_n_o && flag_z_o)); // R9
    if (op_i == OP_INVERT)
      AST_INVERT_CARRY: assert (flag_c_o == carry_i); // R8
    if (op_i > OP_INVERT)
      AST_UNDEF_PASS: assert (result_o == opnd_i && flag_c_o == carry_i); // R11
  end

endmodule

// File: tb/test_shift_rot_unit.sv
module test_shift_rot_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] opnd;
  logic [1:0]  size;
  logic [3:0]  op;
  logic        cin;
  logic [31:0] result;
  logic        fn, fz, fv, fc;
  int          checks = 0;
  int          failures = 0;
  int          cycles = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rot_unit i_shift_rot_unit (
    .opnd_i(opnd), .size_i(size), .op_i(op), .carry_i(cin),
    .result_o(result), .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic string req_of(int o);
    case (o)
      0, 2: return "R2";
      1: return "R3";
      3: return "R4";
      4, 5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s size=%0d op=%0d opnd=%h cin=%0d actual=%h expected=%h",
               req, size, op, opnd, cin, act, exp);
    end
  endtask

  task automatic run_one(logic [31:0] x, int sz, int o, logic ci);
    longint w, mask, v, msb, lsb, r, top, c;
    logic [31:0] exp_res;
    @(posedge clk);
    opnd = x; size = sz[1:0]; op = o[3:0]; cin = ci;
    w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (longint'(1) << w) - 1;
    top  = longint'(1) << (w - 1);
    v    = longint'(x) & mask;
    msb  = (v / top) % 2;
    lsb  = v % 2;
    c    = ci;
    case (o)
      0, 2: begin r = (v * 2) & mask; c = msb; end
      1:    begin r = v / 2; c = lsb; end
      3:    begin r = v / 2 + msb * top; c = lsb; end
      4:    begin r = ((v * 2) & mask) + msb; c = msb; end
      5:    begin r = v / 2 + lsb * top; c = lsb; end
      6:    begin r = ((v * 2) & mask) + ci; c = msb; end
      7:    begin r = v / 2 + ci * top; c = lsb; end
      8:    r = mask - v;
      default: r = v;
    endcase
    exp_res = (x & ~mask[31:0]) | r[31:0];
    @(negedge clk);
    chk(req_of(o), result & mask[31:0], r[31:0]);
    chk("R1", result & ~mask[31:0], x & ~mask[31:0]);
    chk(req_of(o), {31'd0, fc}, {31'd0, c[0]});
    chk("R9", {30'd0, fn, fz}, {30'd0, (r / top) % 2 == 1, r == 0});
    chk("R10", {31'd0, fv}, 32'd0);
    if (result !== exp_res) chk("R1", result, exp_res);
  endtask

  function automatic logic [31:0] pattern(int i, logic [31:0] rnd);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h0000_0001;
      4: return 32'h0000_8000;
      5: return 32'h0000_0080;
      6: return 32'h5555_5555;
      7: return 32'hAAAA_AAAA;
      8: return 32'h7FFF_FFFF;
      9: return 32'hFFFF_7FFF;
      default: return rnd;
    endcase
  endfunction

  initial begin
    opnd = '0; size = '0; op = '0; cin = 1'b0;
    // Reset/idle state: zero operand, logical left, byte field (R2, R9)
    #(CLK_PERIOD/2 + 1);
    chk("R2", result, 32'd0);
    chk("R9", {30'd0, fn, fz}, 32'd1);
    // Exhaustive byte field sweep with random upper bits (R1..R11)
    for (int b = 0; b < 256; b++)
      for (int o = 0; o < 16; o++)
        for (int ci = 0; ci < 2; ci++) begin
          lcg = lcg * 32'd1664525 + 32'd1013904223;
          run_one({lcg[31:8], b[7:0]}, 0, o, ci[0]);
        end
    // Word and long fields, size code 3 aliases long (R1)
    for (int sz = 1; sz < 4; sz++)
      for (int i = 0; i < 40; i++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        for (int o = 0; o < 16; o++)
          for (int ci = 0; ci < 2; ci++)
            run_one(pattern(i, lcg), sz, o, ci[0]);
      end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule